// File: doc/BRIEF.md
# Sixteen-Bit Multi-Function ALU

This block is the purely combinational arithmetic and logic unit of a small load-store processor. Two 16-bit operands and a 4-bit function code go in, and one 16-bit result comes out within the same cycle. The block holds no state, so the surrounding datapath can sample `result` in the same cycle in which it presents the operands and the function code.

Twelve operations share one output. They are wrapping add and subtract, three signed compares that return 0 or 1, the bitwise AND, OR and XOR, a pass-through of operand B, and one barrel shifter. The shifter handles left, logical right and arithmetic right shifts. The shift amount comes from the low bits of operand B. The compares reuse the subtractor and do not have a comparator of their own. Function codes that have no operation assigned give zero.

Top module: `alu16`

The block has no state register, so it has no states and no transitions. Each function code acts as one of its "modes", and the function code alone selects it:

- 0x0 add
- 0x1 subtract
- 0x4 equal
- 0x5 signed less-than
- 0x6 signed less-or-equal
- 0x8 AND
- 0x9 OR
- 0xA XOR
- 0xB pass B
- 0xC shift left
- 0xD shift right logical
- 0xE shift right arithmetic

## Requirements
- R1: Code 0x0 gives (A + B) mod 2^16, with no trap on overflow.
- R2: Code 0x1 gives (A - B) mod 2^16, computed as A + ~B + 1.
- R3: Code 0x4 gives 16'h0001 when A equals B, and 16'h0000 otherwise.
- R4: Code 0x5 gives 16'h0001 when A < B as signed two's complement values, and 16'h0000 otherwise.
- R5: Code 0x6 gives 16'h0001 when A <= B as signed values, and 16'h0000 otherwise.
- R6: Codes 0x8, 0x9 and 0xA give the bitwise AND, OR and XOR of A and B.
- R7: Code 0xB gives B unchanged, and A has no effect on the result.
- R8: Code 0xC shifts A left by B[3:0] places and fills with zeros. B[15:4] has no effect.
- R9: Code 0xD shifts A right by B[3:0] places and fills with zeros.
- R10: Code 0xE shifts A right by B[3:0] places and fills with copies of A[15].
- R11: Codes 0x2, 0x3, 0x7 and 0xF give 16'h0000 for any operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand, and the value that is shifted |
| op_b | input | 16 | Second operand. Its low 4 bits set the shift amount |
| fn_sel | input | 4 | Function code |
| result | output | 16 | Result of the selected operation |

## Verification
The compare cases are the hardest to reach from the ports. Equal operands almost never occur when both operands are drawn at random, yet R3 and R5 turn on that case. The signed compares also fail only when the internal subtraction overflows. To reach both, half of the random draws copy A into B. Directed vectors place the operands on either side of the 0x7FFF/0x8000 boundary. A further directed case sets nonzero upper bits in B while its low four bits are zero, which shows that the shifter ignores B[15:4].

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    typedef enum logic [3:0] {
        FN_ADD  = 4'h0,
        FN_SUB  = 4'h1,
        FN_EQ   = 4'h4,
        FN_LT   = 4'h5,
        FN_LE   = 4'h6,
        FN_AND  = 4'h8,
        FN_OR   = 4'h9,
        FN_XOR  = 4'hA,
        FN_PASS = 4'hB,
        FN_SHL  = 4'hC,
        FN_SHR  = 4'hD,
        FN_SRA  = 4'hE
    } alu_fn_e;

    typedef enum logic [1:0] {
        LG_AND  = 2'd0,
        LG_OR   = 2'd1,
        LG_XOR  = 2'd2,
        LG_PASS = 2'd3
    } logic_op_e;

endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             lt_signed,
    output logic             is_zero
);
    logic [WIDTH-1:0] b_eff;
    logic             ovf;

    always_comb begin
        b_eff     = sub ? ~b : b;
        sum       = a + b_eff + {{(WIDTH-1){1'b0}}, sub};
        // Signed overflow: both addends share a sign and the sum's sign differs.
        ovf       = (a[WIDTH-1] == b_eff[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1]);
        lt_signed = sum[WIDTH-1] ^ ovf;
        is_zero   = ~|sum;
    end
endmodule

// File: rtl/alu16_logic.sv
module alu16_logic
    import alu16_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic_op_e        op,
    output logic [WIDTH-1:0] y
);
    always_comb begin
        unique case (op)
            LG_AND:  y = a & b;
            LG_OR:   y = a | b;
            LG_XOR:  y = a ^ b;
            LG_PASS: y = b;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/alu16_shift.sv
module alu16_shift #(
    parameter int WIDTH = 16,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] a,
    input  logic [SHW-1:0]   amt,
    input  logic             left,
    input  logic             arith,
    output logic [WIDTH-1:0] y
);
    logic [WIDTH-1:0] a_rev;
    logic [WIDTH-1:0] out_rev;
    logic [WIDTH-1:0] stg [0:SHW];
    logic             fill;

    // A left shift is done as a right shift of the bit-reversed word.
    for (genvar i = 0; i < WIDTH; i++) begin : g_rev
        assign a_rev[i]   = a[WIDTH-1-i];
        assign out_rev[i] = stg[SHW][WIDTH-1-i];
    end

    assign fill   = arith & ~left & a[WIDTH-1];
    assign stg[0] = left ? a_rev : a;

    // One stage per bit of the shift amount; stage k moves the word by 2**k places.
    for (genvar k = 0; k < SHW; k++) begin : g_stage
        assign stg[k+1] = amt[k] ? {{(2**k){fill}}, stg[k][WIDTH-1:(2**k)]}
                                 : stg[k];
    end

    assign y = left ? out_rev : stg[SHW];
endmodule

// File: rtl/alu16.sv
module alu16
    import alu16_pkg::*;
#(
    parameter int WIDTH = 16,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [3:0]       fn_sel,
    output logic [WIDTH-1:0] result
);
    logic [WIDTH-1:0] as_sum;
    logic             as_lt;
    logic             as_zero;
    logic [WIDTH-1:0] lg_y;
    logic [WIDTH-1:0] sh_y;
    logic_op_e        lg_op;
    logic             is_sub;

    assign is_sub = (fn_sel != FN_ADD);
    assign lg_op  = logic_op_e'(fn_sel[1:0]);

    alu16_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a(op_a), .b(op_b), .sub(is_sub),
        .sum(as_sum), .lt_signed(as_lt), .is_zero(as_zero)
    );

    alu16_logic #(.WIDTH(WIDTH)) u_logic (
        .a(op_a), .b(op_b), .op(lg_op), .y(lg_y)
    );

    alu16_shift #(.WIDTH(WIDTH)) u_shift (
        .a(op_a), .amt(op_b[SHW-1:0]),
        .left(fn_sel == FN_SHL), .arith(fn_sel == FN_SRA),
        .y(sh_y)
    );

    always_comb begin
        case (fn_sel)
            FN_ADD, FN_SUB:                  result = as_sum;
            FN_EQ:                           result = {{(WIDTH-1){1'b0}}, as_zero};
            FN_LT:                           result = {{(WIDTH-1){1'b0}}, as_lt};
            FN_LE:                           result = {{(WIDTH-1){1'b0}}, as_lt | as_zero};
            FN_AND, FN_OR, FN_XOR, FN_PASS:  result = lg_y;
            FN_SHL, FN_SHR, FN_SRA:          result = sh_y;
            default:                         result = '0;
        endcase
    end

    always_comb begin
        // R2
        if (fn_sel == FN_SUB)
            sub_inverts_add_chk: assert (result + op_b == op_a);
        // R3
        if (fn_sel == FN_EQ)
            eq_matches_operands_chk: assert (result == {{(WIDTH-1){1'b0}}, op_a == op_b});
        // R7
        if (fn_sel == FN_PASS)
            pass_b_chk: assert (result == op_b);
        // R8
        if (fn_sel == FN_SHL && op_b[SHW-1:0] != '0)
            shl_low_zero_chk: assert (result[0] == 1'b0);
        // R10
        if (fn_sel == FN_SRA)
            sra_sign_kept_chk: assert (result[WIDTH-1] == op_a[WIDTH-1]);
        // R11
        if (fn_sel == 4'h2 || fn_sel == 4'h3 || fn_sel == 4'h7 || fn_sel == 4'hF)
            unused_zero_chk: assert (result == '0);
    end
endmodule

// File: tb/test_alu16.sv
module test_alu16;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic [15:0] op_a, op_b;
    logic [3:0]  fn_sel;
    logic [15:0] result;
    int          n_run  = 0;
    int          n_fail = 0;
    bit          done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu16 i_alu16 (.op_a(op_a), .op_b(op_b), .fn_sel(fn_sel), .result(result));

    function automatic logic [15:0] ref_model(logic [3:0] f, logic [15:0] a, logic [15:0] b);
        case (f)
            4'h0: return a + b;
            4'h1: return a - b;
            4'h4: return {15'b0, a == b};
            4'h5: return {15'b0, $signed(a) <  $signed(b)};
            4'h6: return {15'b0, $signed(a) <= $signed(b)};
            4'h8: return a & b;
            4'h9: return a | b;
            4'hA: return a ^ b;
            4'hB: return b;
            4'hC: return a << b[3:0];
            4'hD: return a >> b[3:0];
            4'hE: return 16'($signed(a) >>> b[3:0]);
            default: return 16'h0000;
        endcase
    endfunction

    function automatic string req_of(logic [3:0] f);
        case (f)
            4'h0: return "R1";
            4'h1: return "R2";
            4'h4: return "R3";
            4'h5: return "R4";
            4'h6: return "R5";
            4'h8, 4'h9, 4'hA: return "R6";
            4'hB: return "R7";
            4'hC: return "R8";
            4'hD: return "R9";
            4'hE: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic apply(input logic [3:0] f, input logic [15:0] a, input logic [15:0] b);
        logic [15:0] exp;
        @(posedge clk);
        fn_sel = f; op_a = a; op_b = b;
        @(negedge clk);
        exp = ref_model(f, a, b);
        n_run++;
        if (result !== exp) begin
            n_fail++;
            $display("FAIL %s fn=%h a=%h b=%h actual=%h expected=%h",
                     req_of(f), f, a, b, result, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        fn_sel = 4'h0; op_a = '0; op_b = '0;
        // R1: all-zero start
        apply(4'h0, 16'h0000, 16'h0000);
        // R1: wrap and signed overflow without trap
        apply(4'h0, 16'hFFFF, 16'h0001);
        apply(4'h0, 16'h7FFF, 16'h0001);
        // R2: borrow through zero and most-negative
        apply(4'h1, 16'h0000, 16'h0001);
        apply(4'h1, 16'h8000, 16'h0001);
        // R3
        apply(4'h4, 16'h1234, 16'h1234);
        apply(4'h4, 16'h1234, 16'h1235);
        // R4: operands straddling the sign boundary
        apply(4'h5, 16'h8000, 16'h7FFF);
        apply(4'h5, 16'h7FFF, 16'h8000);
        apply(4'h5, 16'h0005, 16'h0005);
        // R5
        apply(4'h6, 16'h0005, 16'h0005);
        apply(4'h6, 16'h7FFF, 16'h8000);
        apply(4'h6, 16'hFFFF, 16'h0000);
        // R6
        apply(4'h8, 16'hF0F0, 16'hFF00);
        apply(4'h9, 16'hF0F0, 16'h0F00);
        apply(4'hA, 16'hAAAA, 16'hFFFF);
        // R7: A has no effect
        apply(4'hB, 16'hDEAD, 16'h00BE);
        apply(4'hB, 16'h0000, 16'h00BE);
        // R8: upper bits of B ignored, full-width shift
        apply(4'hC, 16'h1234, 16'hFFF0);
        apply(4'hC, 16'hFFFF, 16'h000F);
        // R9
        apply(4'hD, 16'h8000, 16'h000F);
        // R10
        apply(4'hE, 16'h8000, 16'h000F);
        apply(4'hE, 16'h4000, 16'h000E);
        // R11: every unassigned code
        apply(4'h2, 16'hFFFF, 16'hFFFF);
        apply(4'h3, 16'h1234, 16'h5678);
        apply(4'h7, 16'hFFFF, 16'h0001);
        apply(4'hF, 16'h8000, 16'h7FFF);
        // Random sweep of all codes; half the draws make B equal to A
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] ra, rb;
            ra = 16'($urandom);
            rb = ($urandom % 2 == 0) ? ra : 16'($urandom);
            apply(4'($urandom), ra, rb);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule